// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Self-Test Unit

This unit gathers the interrupt events of a four-channel SPI controller into a single interrupt line. On each update strobe, a channel reports its state: transmit holding register empty, receive register full, transfer mode and turbo flag. The unit turns these into sticky status bits, masks them with an enable register and ORs the result into `irq`. Software clears status bits by writing ones to them. It also programs the enable register, a test register, a module-control register, a configuration register and a wakeup-enable bit, all through one write port. A combinational read port returns any of these registers.

The unit also has a self-test path. When the test flag in module control and the force flag in the test register are both set, every implemented status bit is driven to one and software clears are ignored. This lets software check the whole interrupt path without running a transfer.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset, status, enable, test, configuration and wakeup read 0, module control reads 4, and `irq` is low.
- R2: Register select codes are 0 configuration, 1 status, 2 enable, 3 wakeup, 4 test, 5 module control. When channel n strobes `ch_upd[n]`, status bit 4n is set if `ch_txs[n]` is high and its mode is not 1. Status bit 4n+2 is set if `ch_rxs[n]` is high, its mode is not 2 and `ch_turbo[n]` is low. Mode codes are 0 full duplex, 1 receive only, 2 transmit only, and 3 is treated as 0.
- R3: `irq` is high exactly when some bit is set in both status and enable. The enable register keeps only the implemented bits 0x1777F.
- R4: A write to status clears each bit written as 1 and leaves the other bits unchanged.
- R5: A write to status has no effect while module-control bit 3 and test bit 11 are both set.
- R6: A write to the test register with bit 11 set, while module-control bit 3 is set, sets every status bit in 0x1777F.
- R7: A write to module control with bit 3 set, while test bit 11 is already set, sets every status bit in 0x1777F.
- R8: The test register stores the low 12 bits of the write and module control stores the low 4 bits.
- R9: A write to configuration with bit 1 set clears status, enable, test and wakeup and returns module control to 4. Configuration stores the written value ANDed with 0x31D, whether or not bit 1 is set.
- R10: When a channel event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R11: The wakeup register stores bit 0 of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_upd | input | NUM_CH | Per-channel event strobe |
| ch_txs | input | NUM_CH | Channel transmit register empty |
| ch_rxs | input | NUM_CH | Channel receive register full |
| ch_mode | input | 2*NUM_CH | Channel transfer mode, 2 bits per channel |
| ch_turbo | input | NUM_CH | Channel turbo flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data, zero-extended |
| irq | output | 1 | Interrupt output |

## Verification
The event decode is driven from a table of channel, flag, mode and turbo combinations. Each entry starts from a cleared status register, so a wrong bit position, a missing mode gate or a missing turbo gate shows up as a distinct status value.

Directed tests then cover the self-test controls:
- both entry orders of self-test: test register first and module control first;
- a clear attempted while self-test forcing is active, compared with one made after forcing is dropped;
- a clear and an event arriving in the same cycle.

A configuration write without bit 1 is checked against one with bit 1, to show that only the latter resets state.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_CH_DEF    = 4;
    localparam int DATA_W_DEF    = 32;
    localparam int TEST_W        = 12;
    localparam int MCTL_W        = 4;
    localparam int CFG_W         = 10;
    localparam int SEL_W         = 3;
    localparam int TEST_SSB_BIT  = 11;
    localparam int MCTL_TEST_BIT = 3;
    localparam int CFG_SRST_BIT  = 1;

    localparam logic [CFG_W-1:0]  CFG_KEEP = 10'h31D;
    localparam logic [MCTL_W-1:0] MCTL_RST = 4'h4;

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG  = 3'd0,
        SEL_STAT = 3'd1,
        SEL_IEN  = 3'd2,
        SEL_WAKE = 3'd3,
        SEL_TEST = 3'd4,
        SEL_MCTL = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        TRM_BOTH   = 2'd0,
        TRM_RXONLY = 2'd1,
        TRM_TXONLY = 2'd2,
        TRM_RSVD   = 2'd3
    } trm_e;

    typedef struct packed {
        logic upd;
        logic txs;
        logic rxs;
        trm_e trm;
        logic turbo;
    } ch_evt_t;

    // Implemented status bits: three per channel, bit 3, and the bit above the last channel.
    function automatic logic [63:0] impl_mask(input int nch);
        logic [63:0] m;
        m = '0;
        for (int n = 0; n < nch; n++) begin
            m[4*n +: 3] = 3'b111;
        end
        m[3]     = 1'b1;
        m[4*nch] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/spi_irq_evt.sv
module spi_irq_evt
    import spi_irq_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int STAT_W = 4*NUM_CH+1
) (
    input  ch_evt_t           ev [NUM_CH],
    output logic [STAT_W-1:0] set_vec
);

    logic [NUM_CH-1:0] tx_hit;
    logic [NUM_CH-1:0] rx_hit;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_comb begin
            tx_hit[i] = ev[i].upd && ev[i].txs && (ev[i].trm != TRM_RXONLY);
            rx_hit[i] = ev[i].upd && ev[i].rxs && (ev[i].trm != TRM_TXONLY)
                        && !ev[i].turbo;
        end
    end

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            set_vec[4*i]     = tx_hit[i];
            set_vec[4*i + 2] = rx_hit[i];
        end
    end

endmodule

// File: rtl/spi_irq_ctl.sv
module spi_irq_ctl
    import spi_irq_pkg::*;
#(
    parameter int                STAT_W = 17,
    parameter int                DATA_W = DATA_W_DEF,
    parameter logic [STAT_W-1:0] IMPL   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [STAT_W-1:0] ien_q,
    output logic [TEST_W-1:0] test_q,
    output logic [MCTL_W-1:0] mctl_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              wake_q,
    output logic              srst,
    output logic [STAT_W-1:0] clr,
    output logic              force_all
);

    logic test_mode;
    logic ssb;
    logic hold_clear;
    logic unused_hi;

    assign unused_hi  = ^wr_data[DATA_W-1:STAT_W];
    assign test_mode  = mctl_q[MCTL_TEST_BIT];
    assign ssb        = test_q[TEST_SSB_BIT];
    assign hold_clear = test_mode && ssb;

    always_comb begin
        srst      = wr_en && (wr_sel == SEL_CFG) && wr_data[CFG_SRST_BIT];
        clr       = (wr_en && (wr_sel == SEL_STAT) && !hold_clear)
                    ? wr_data[STAT_W-1:0] : '0;
        force_all = wr_en && (((wr_sel == SEL_TEST) && wr_data[TEST_SSB_BIT] && test_mode)
                           || ((wr_sel == SEL_MCTL) && wr_data[MCTL_TEST_BIT] && ssb));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            test_q <= '0;
            mctl_q <= MCTL_RST;
            cfg_q  <= '0;
            wake_q <= 1'b0;
        end else if (srst) begin
            ien_q  <= '0;
            test_q <= '0;
            mctl_q <= MCTL_RST;
            wake_q <= 1'b0;
            cfg_q  <= wr_data[CFG_W-1:0] & CFG_KEEP;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CFG:  cfg_q  <= wr_data[CFG_W-1:0] & CFG_KEEP;
                SEL_IEN:  ien_q  <= wr_data[STAT_W-1:0] & IMPL;
                SEL_WAKE: wake_q <= wr_data[0];
                SEL_TEST: test_q <= wr_data[TEST_W-1:0];
                SEL_MCTL: mctl_q <= wr_data[MCTL_W-1:0];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/spi_irq_stat.sv
module spi_irq_stat
    import spi_irq_pkg::*;
#(
    parameter int                STAT_W = 17,
    parameter logic [STAT_W-1:0] IMPL   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic [STAT_W-1:0] clr,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              force_all,
    output logic [STAT_W-1:0] stat_q
);

    logic [STAT_W-1:0] stat_d;

    // Clear first, then events and forcing, so a same-cycle event survives.
    always_comb begin
        stat_d = stat_q & ~clr;
        stat_d = stat_d | set_vec;
        if (force_all) begin
            stat_d = stat_d | IMPL;
        end
        stat_d = stat_d & IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CH-1:0]   ch_upd,
    input  logic [NUM_CH-1:0]   ch_txs,
    input  logic [NUM_CH-1:0]   ch_rxs,
    input  logic [2*NUM_CH-1:0] ch_mode,
    input  logic [NUM_CH-1:0]   ch_turbo,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq
);

    localparam int                STAT_W = 4*NUM_CH + 1;
    localparam logic [63:0]       IMPL64 = impl_mask(NUM_CH);
    localparam logic [STAT_W-1:0] IMPL   = IMPL64[STAT_W-1:0];

    ch_evt_t           ev [NUM_CH];
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] ien_q;
    logic [TEST_W-1:0] test_q;
    logic [MCTL_W-1:0] mctl_q;
    logic [CFG_W-1:0]  cfg_q;
    logic              wake_q;
    logic              srst;
    logic [STAT_W-1:0] clr;
    logic              force_all;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pack
        assign ev[i] = '{upd:   ch_upd[i],
                         txs:   ch_txs[i],
                         rxs:   ch_rxs[i],
                         trm:   trm_e'(ch_mode[2*i +: 2]),
                         turbo: ch_turbo[i]};
    end

    spi_irq_evt #(.NUM_CH(NUM_CH), .STAT_W(STAT_W)) u_evt (
        .ev      (ev),
        .set_vec (set_vec)
    );

    spi_irq_ctl #(.STAT_W(STAT_W), .DATA_W(DATA_W), .IMPL(IMPL)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (reg_sel_e'(wr_sel)),
        .wr_data   (wr_data),
        .ien_q     (ien_q),
        .test_q    (test_q),
        .mctl_q    (mctl_q),
        .cfg_q     (cfg_q),
        .wake_q    (wake_q),
        .srst      (srst),
        .clr       (clr),
        .force_all (force_all)
    );

    spi_irq_stat #(.STAT_W(STAT_W), .IMPL(IMPL)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .srst      (srst),
        .clr       (clr),
        .set_vec   (set_vec),
        .force_all (force_all),
        .stat_q    (stat_q)
    );

    assign irq = |(stat_q & ien_q);

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_CFG:  rd_data[CFG_W-1:0]  = cfg_q;
            SEL_STAT: rd_data[STAT_W-1:0] = stat_q;
            SEL_IEN:  rd_data[STAT_W-1:0] = ien_q;
            SEL_WAKE: rd_data[0]          = wake_q;
            SEL_TEST: rd_data[TEST_W-1:0] = test_q;
            SEL_MCTL: rd_data[MCTL_W-1:0] = mctl_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
    import spi_irq_pkg::*;
#(
    parameter int                STAT_W = 17,
    parameter int                DATA_W = 32,
    parameter logic [STAT_W-1:0] IMPL   = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] ien_q,
    input logic [TEST_W-1:0] test_q,
    input logic [MCTL_W-1:0] mctl_q,
    input logic [STAT_W-1:0] set_vec
);

    logic soft_wr;
    assign soft_wr = wr_en && (wr_sel == SEL_CFG) && wr_data[CFG_SRST_BIT];

    p_ien_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (ien_q & ~IMPL) == '0);

    p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

    p_clear_held_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_STAT && mctl_q[MCTL_TEST_BIT] && test_q[TEST_SSB_BIT])
        |=> stat_q == ($past(stat_q) | $past(set_vec)));

    p_force_by_test_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_TEST && wr_data[TEST_SSB_BIT] && mctl_q[MCTL_TEST_BIT])
        |=> stat_q == IMPL);

    p_force_by_mctl_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_MCTL && wr_data[MCTL_TEST_BIT] && test_q[TEST_SSB_BIT])
        |=> stat_q == IMPL);

    p_soft_reset_r9: assert property (@(posedge clk) disable iff (rst)
        soft_wr |=> (stat_q == '0) && (ien_q == '0) && (test_q == '0) && (mctl_q == MCTL_RST));

    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        !soft_wr |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

endmodule

bind spi_irq_unit spi_irq_chk #(.STAT_W(STAT_W), .DATA_W(DATA_W), .IMPL(IMPL)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .irq     (irq),
    .stat_q  (stat_q),
    .ien_q   (ien_q),
    .test_q  (test_q),
    .mctl_q  (mctl_q),
    .set_vec (set_vec)
);

// File: tb/spi_irq_unit_bench.sv
module spi_irq_unit_bench;

    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam logic [2:0] R_CFG = 3'd0, R_STAT = 3'd1, R_IEN = 3'd2,
                           R_WAKE = 3'd3, R_TEST = 3'd4, R_MCTL = 3'd5;
    localparam int NVEC = 10;
    // {ch[23:22], txs[21], rxs[20], mode[19:18], turbo[17], expected status[16:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 17'h00005},
        {2'd0, 1'b1, 1'b1, 2'd1, 1'b0, 17'h00004},
        {2'd0, 1'b1, 1'b1, 2'd2, 1'b0, 17'h00001},
        {2'd1, 1'b1, 1'b1, 2'd0, 1'b1, 17'h00010},
        {2'd2, 1'b0, 1'b1, 2'd0, 1'b0, 17'h00400},
        {2'd3, 1'b1, 1'b0, 2'd0, 1'b0, 17'h01000},
        {2'd3, 1'b1, 1'b1, 2'd3, 1'b0, 17'h05000},
        {2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 17'h00000},
        {2'd2, 1'b1, 1'b1, 2'd2, 1'b1, 17'h00100},
        {2'd3, 1'b0, 1'b1, 2'd1, 1'b0, 17'h04000}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  ch_upd = '0, ch_txs = '0, ch_rxs = '0, ch_turbo = '0;
    logic [2*NCH-1:0] ch_mode = '0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_sel = '0, rd_sel = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [DW-1:0]   rd_data;
    logic            irq;

    int total = 0;
    int failed = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_irq_unit u_spi_irq_unit (
        .clk(clk), .rst(rst), .ch_upd(ch_upd), .ch_txs(ch_txs), .ch_rxs(ch_rxs),
        .ch_mode(ch_mode), .ch_turbo(ch_turbo), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [2:0] sel, input logic [DW-1:0] exp);
        rd_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [DW-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ch(input int ch, input logic tx, input logic rx,
                          input logic [1:0] mode, input logic turbo);
        ch_upd = '0; ch_upd[ch] = 1'b1;
        ch_txs = '0; ch_txs[ch] = tx;
        ch_rxs = '0; ch_rxs[ch] = rx;
        ch_turbo = '0; ch_turbo[ch] = turbo;
        ch_mode = '0; ch_mode[2*ch +: 2] = mode;
    endtask

    task automatic pulse(input int ch, input logic tx, input logic rx,
                         input logic [1:0] mode, input logic turbo);
        @(negedge clk);
        set_ch(ch, tx, rx, mode, turbo);
        @(negedge clk);
        ch_upd = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_check("R1 cfg", R_CFG, 0);
        rd_check("R1 stat", R_STAT, 0);
        rd_check("R1 ien", R_IEN, 0);
        rd_check("R1 wake", R_WAKE, 0);
        rd_check("R1 test", R_TEST, 0);
        rd_check("R1 mctl", R_MCTL, 4);
        check("R1 irq", {31'd0, irq}, 0);

        // R2 event decode table
        for (int k = 0; k < NVEC; k++) begin
            wr(R_STAT, 32'h1FFFF);
            pulse(int'(VEC[k][23:22]), VEC[k][21], VEC[k][20], VEC[k][19:18], VEC[k][17]);
            rd_check($sformatf("R2 vector %0d", k), R_STAT, {15'd0, VEC[k][16:0]});
        end

        // R3 enable mask and irq
        wr(R_IEN, 32'hFFFFFFFF);
        rd_check("R3 ien mask", R_IEN, 32'h1777F);
        check("R3 irq on", {31'd0, irq}, 1);
        wr(R_IEN, 32'h1);
        check("R3 irq masked", {31'd0, irq}, 0);

        // R4 write one to clear
        wr(R_STAT, 32'h1FFFF);
        pulse(0, 1, 1, 2'd0, 0);
        wr(R_STAT, 32'h1);
        rd_check("R4 partial clear", R_STAT, 32'h4);
        wr(R_IEN, 32'h4);
        check("R3 irq enabled bit", {31'd0, irq}, 1);

        // R8 widths, R6 negative, R7, R5, R6
        wr(R_TEST, 32'hFFFF);
        rd_check("R8 test width", R_TEST, 32'hFFF);
        rd_check("R6 no force without test mode", R_STAT, 32'h4);
        wr(R_MCTL, 32'hFF);
        rd_check("R8 mctl width", R_MCTL, 32'hF);
        rd_check("R7 force by mctl", R_STAT, 32'h1777F);
        wr(R_STAT, 32'h1FFFF);
        rd_check("R5 clear held", R_STAT, 32'h1777F);
        wr(R_TEST, 32'h0);
        rd_check("R6 no force when bit11 clear", R_STAT, 32'h1777F);
        wr(R_STAT, 32'h1FFFF);
        rd_check("R4 clear after force dropped", R_STAT, 32'h0);
        wr(R_TEST, 32'h800);
        rd_check("R6 force by test", R_STAT, 32'h1777F);
        wr(R_MCTL, 32'h0);
        wr(R_STAT, 32'h1FFFF);
        rd_check("R4 clear with test mode off", R_STAT, 32'h0);

        // R10 event beats same-cycle clear
        pulse(3, 1, 1, 2'd0, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = R_STAT; wr_data = 32'h1FFFF;
        set_ch(0, 1, 0, 2'd0, 0);
        @(negedge clk);
        wr_en = 1'b0; ch_upd = '0;
        rd_check("R10 event wins", R_STAT, 32'h1);

        // R11 wakeup
        wr(R_WAKE, 32'hFFFFFFFF);
        rd_check("R11 wake bit", R_WAKE, 32'h1);

        // R9 configuration without and with soft reset
        wr(R_IEN, 32'hFFFF);
        wr(R_TEST, 32'h123);
        wr(R_MCTL, 32'h3);
        wr(R_CFG, 32'hFD);
        rd_check("R9 cfg mask no reset", R_CFG, 32'h01D);
        rd_check("R9 stat kept", R_STAT, 32'h1);
        wr(R_CFG, 32'hFFFFFFFF);
        rd_check("R9 cfg mask", R_CFG, 32'h31D);
        rd_check("R9 stat cleared", R_STAT, 0);
        rd_check("R9 ien cleared", R_IEN, 0);
        rd_check("R9 test cleared", R_TEST, 0);
        rd_check("R9 wake cleared", R_WAKE, 0);
        rd_check("R9 mctl restored", R_MCTL, 4);
        check("R9 irq low", {31'd0, irq}, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule